// File: doc/BRIEF.md
# Fax Codec Line-Count Job Sequencer

This block runs one encode or decode job over a bilevel image that sits in external word-wide memory. Software programs a 24-bit start address, a line count, a line width in 16-bit words and a set of interrupt enables, then writes a control word that starts the job. In the encode direction the sequencer reads image words in ascending address order and hands each word to the encoder, which feeds the encode FIFO. In the decode direction it takes decoded pixel words from the decode FIFO side and writes them back to memory in ascending order.

Each direction keeps its own address pointer. A job may restart from the programmed base or resume where the last job of the same direction stopped, so short encode and decode jobs can alternate a few lines at a time. A job covers either a whole block of lines or one line only. Done and error status bits are sticky until software clears them, and the interrupt output is the OR of the enabled status bits.

The state machine has four states. IDLE waits for a start. XFER moves one word per granted memory cycle. LINE_END closes a line. DONE closes the job. The named transitions are: start (IDLE to XFER), line_full (XFER to LINE_END on the last word of a line), next_line (LINE_END to XFER), job_full (LINE_END to DONE on the last line), retire (DONE to IDLE) and abort (XFER, LINE_END or DONE to IDLE on a decode error).

Top module: `fxjob_seq`

## Requirements
- R1: After reset the block is idle: busy, mem_req, irq and both status bits are 0.
- R2: In encode mode the first request carries the selected start address, and each granted transfer advances the address by one. Each granted word appears on enc_word with enc_push high in the same cycle. A request is never made while enc_full is high.
- R3: In decode mode every request has mem_we high and mem_wdata equal to dec_word. A granted transfer pulses dec_pop. A request is made only while dec_valid is high.
- R4: A block job moves exactly (lines+1)*(width+1) words. Here lines is the value written to select 1 and width is the value written to select 2. The job then sets status bit 0 (done), and busy is low by the time that bit shows.
- R5: With control bit 2 (single line) set, a job moves exactly width+1 words, whatever the line count.
- R6: With control bit 3 (resume) set, a job starts at the word after the last one moved by the previous job of the same direction, and the base register is ignored. The encode and decode pointers are independent.
- R7: A start written while a job is busy is ignored: the running job keeps its direction and its length.
- R8: dec_err during a decode job ends the job at the next edge. Busy and mem_req go low and status bit 1 (error) is set. dec_err has no effect during an encode job.
- R9: Status bits stay set until a write to select 5 has 1 in the same bit position (bit 0 done, bit 1 error).
- R10: irq is high exactly when some status bit is set and its enable bit is set (select 4, bit 0 done, bit 1 error).
- R11: Register selects: 0 base address, 1 lines minus one, 2 words per line minus one, 3 control (bit 0 start, bit 1 decode, bit 2 single line, bit 3 resume), 4 interrupt enables, 5 status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 24 | Register write data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write (decode) |
| mem_addr | output | 24 | Word address of the transfer |
| mem_wdata | output | 16 | Write data to memory |
| mem_gnt | input | 1 | Transfer completes at this edge |
| mem_rdata | input | 16 | Read data from memory |
| enc_full | input | 1 | Encoder path cannot take a word |
| enc_push | output | 1 | Word handed to the encoder |
| enc_word | output | 16 | Image word for the encoder |
| dec_valid | input | 1 | Decoded word available |
| dec_word | input | 16 | Decoded image word |
| dec_pop | output | 1 | Decoded word consumed |
| dec_err | input | 1 | Decoder reports an error |
| busy | output | 1 | Job in progress |
| sts | output | 2 | Status: bit 0 done, bit 1 error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the memory side asserts mem_gnt only while mem_req is high. They also assume that enc_full, dec_valid and dec_err are held steady across each clock edge. The bench drives every input half a cycle away from the active edge. It derives mem_gnt from the request it sees, never on its own. It holds grants back in the cycle where it raises a decode error, so that no word is in flight when a job aborts.

// File: rtl/fxjob_pkg.sv
package fxjob_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_LINE_END,
        ST_DONE
    } job_state_t;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_BASE   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_LINES  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_WIDTH  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_IRQEN  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd5;

    localparam int CTRL_GO     = 0;
    localparam int CTRL_DEC    = 1;
    localparam int CTRL_SINGLE = 2;
    localparam int CTRL_RESUME = 3;

    localparam int NSTS = 2;
endpackage

// File: rtl/fxjob_regs.sv
module fxjob_regs
    import fxjob_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             done_set,
    input  logic             err_set,
    output logic [AW-1:0]    base_addr,
    output logic [CW-1:0]    lines_m1,
    output logic [CW-1:0]    width_m1,
    output logic             go,
    output logic             go_dec,
    output logic             go_single,
    output logic             go_resume,
    output logic [NSTS-1:0]  sts,
    output logic             irq
);
    logic [AW-1:0]   base_q;
    logic [CW-1:0]   lines_q;
    logic [CW-1:0]   width_q;
    logic [NSTS-1:0] ie_q;
    logic [NSTS-1:0] sts_q;
    logic [NSTS-1:0] sts_clr;
    logic [NSTS-1:0] sts_set;

    always_comb begin
        sts_clr = (cfg_we && cfg_sel == SEL_STATUS) ? cfg_wdata[NSTS-1:0] : '0;
        sts_set = {err_set, done_set};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            lines_q <= '0;
            width_q <= '0;
            ie_q    <= '0;
            sts_q   <= '0;
        end else begin
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_BASE:  base_q  <= cfg_wdata;
                    SEL_LINES: lines_q <= cfg_wdata[CW-1:0];
                    SEL_WIDTH: width_q <= cfg_wdata[CW-1:0];
                    SEL_IRQEN: ie_q    <= cfg_wdata[NSTS-1:0];
                    default:   ;
                endcase
            end
            sts_q <= (sts_q & ~sts_clr) | sts_set;
        end
    end

    always_comb begin
        go        = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_GO];
        go_dec    = cfg_wdata[CTRL_DEC];
        go_single = cfg_wdata[CTRL_SINGLE];
        go_resume = cfg_wdata[CTRL_RESUME];
        base_addr = base_q;
        lines_m1  = lines_q;
        width_m1  = width_q;
        sts       = sts_q;
        irq       = |(sts_q & ie_q);
    end
endmodule

// File: rtl/fxjob_addr.sv
module fxjob_addr #(
    parameter int AW   = 24,
    parameter int NDIR = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [$clog2(NDIR)-1:0] load_dir,
    input  logic                    resume,
    input  logic [AW-1:0]           base,
    input  logic                    step,
    input  logic [$clog2(NDIR)-1:0] cur_dir,
    output logic [AW-1:0]           addr
);
    localparam int DIRW = $clog2(NDIR);

    logic [AW-1:0] ptr [NDIR];

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_ptr
            logic [AW-1:0] p_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    p_q <= '0;
                end else if (load && load_dir == DIRW'(d)) begin
                    if (!resume) p_q <= base;
                end else if (step && cur_dir == DIRW'(d)) begin
                    p_q <= p_q + {{(AW-1){1'b0}}, 1'b1};
                end
            end
            assign ptr[d] = p_q;
        end
    endgenerate

    assign addr = ptr[cur_dir];
endmodule

// File: rtl/fxjob_fsm.sv
module fxjob_fsm
    import fxjob_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_dec,
    input  logic          go_single,
    input  logic [CW-1:0] lines_m1,
    input  logic [CW-1:0] width_m1,
    input  logic          enc_full,
    input  logic          dec_valid,
    input  logic          dec_err,
    input  logic          mem_gnt,
    output logic          busy,
    output logic          job_dec,
    output logic          load,
    output logic          xfer,
    output logic          mem_req,
    output logic          done_set,
    output logic          err_set
);
    job_state_t    state_q, state_d;
    logic          dec_q, single_q;
    logic [CW-1:0] lines_q, width_q;
    logic [CW-1:0] word_cnt, line_cnt;
    logic          last_word, last_line, err_hit;

    always_comb begin
        last_word = (word_cnt == width_q);
        last_line = single_q || (line_cnt == lines_q);
        err_hit   = (state_q != ST_IDLE) && dec_q && dec_err;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (go) state_d = ST_XFER;
            ST_XFER: begin
                if (err_hit)                 state_d = ST_IDLE;
                else if (xfer && last_word)  state_d = ST_LINE_END;
            end
            ST_LINE_END: begin
                if (err_hit)        state_d = ST_IDLE;
                else if (last_line) state_d = ST_DONE;
                else                state_d = ST_XFER;
            end
            ST_DONE:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        load     = (state_q == ST_IDLE) && go;
        mem_req  = (state_q == ST_XFER) && (dec_q ? dec_valid : !enc_full);
        xfer     = mem_req && mem_gnt;
        done_set = (state_q == ST_DONE) && !err_hit;
        err_set  = err_hit;
        job_dec  = dec_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q    <= 1'b0;
            single_q <= 1'b0;
            lines_q  <= '0;
            width_q  <= '0;
            word_cnt <= '0;
            line_cnt <= '0;
        end else if (load) begin
            dec_q    <= go_dec;
            single_q <= go_single;
            lines_q  <= lines_m1;
            width_q  <= width_m1;
            word_cnt <= '0;
            line_cnt <= '0;
        end else begin
            if (xfer) word_cnt <= last_word ? '0 : word_cnt + {{(CW-1){1'b0}}, 1'b1};
            if (state_q == ST_LINE_END) line_cnt <= line_cnt + {{(CW-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/fxjob_seq.sv
module fxjob_seq
    import fxjob_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_gnt,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             enc_full,
    output logic             enc_push,
    output logic [DW-1:0]    enc_word,
    input  logic             dec_valid,
    input  logic [DW-1:0]    dec_word,
    output logic             dec_pop,
    input  logic             dec_err,
    output logic             busy,
    output logic [NSTS-1:0]  sts,
    output logic             irq
);
    localparam int NDIR = 2;

    logic [AW-1:0] base_addr;
    logic [CW-1:0] lines_m1, width_m1;
    logic          go, go_dec, go_single, go_resume;
    logic          job_dec, load, xfer, done_set, err_set;

    fxjob_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .done_set(done_set), .err_set(err_set),
        .base_addr(base_addr), .lines_m1(lines_m1), .width_m1(width_m1),
        .go(go), .go_dec(go_dec), .go_single(go_single), .go_resume(go_resume),
        .sts(sts), .irq(irq)
    );

    fxjob_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .go_dec(go_dec), .go_single(go_single),
        .lines_m1(lines_m1), .width_m1(width_m1), .enc_full(enc_full),
        .dec_valid(dec_valid), .dec_err(dec_err), .mem_gnt(mem_gnt),
        .busy(busy), .job_dec(job_dec), .load(load), .xfer(xfer),
        .mem_req(mem_req), .done_set(done_set), .err_set(err_set)
    );

    fxjob_addr #(.AW(AW), .NDIR(NDIR)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_dir(go_dec),
        .resume(go_resume), .base(base_addr), .step(xfer),
        .cur_dir(job_dec), .addr(mem_addr)
    );

    always_comb begin
        mem_we    = mem_req && job_dec;
        mem_wdata = dec_word;
        dec_pop   = xfer && job_dec;
        enc_push  = xfer && !job_dec;
        enc_word  = mem_rdata;
    end
endmodule

// File: rtl/fxjob_chk.sv
module fxjob_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          job_dec,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          enc_full,
    input logic          dec_valid,
    input logic          dec_err,
    input logic [1:0]    sts,
    input logic          clr_done,
    input logic          clr_err
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_no_req_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !enc_full);

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_req && mem_gnt) && busy) |-> (mem_addr == $past(mem_addr) + {{(AW-1){1'b0}}, 1'b1}));

    p_dec_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> dec_valid);

    p_done_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[0]) |-> !busy);

    p_err_aborts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && job_dec && dec_err) |=> (!busy && sts[1]));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[0] && !clr_done) |=> sts[0]);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[1] && !clr_err) |=> sts[1]);
endmodule

bind fxjob_seq fxjob_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .job_dec(job_dec),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .enc_full(enc_full), .dec_valid(dec_valid), .dec_err(dec_err), .sts(sts),
    .clr_done(cfg_we && cfg_sel == 3'd5 && cfg_wdata[0]),
    .clr_err(cfg_we && cfg_sel == 3'd5 && cfg_wdata[1])
);

// File: tb/fxjob_seq_bench.sv
`timescale 1ns/1ps
module fxjob_seq_bench;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [23:0] cfg_wdata = '0;
    logic        mem_req, mem_we, enc_push, dec_pop, busy, irq;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, enc_word, mem_rdata;
    logic        mem_gnt = 1'b0;
    logic        enc_full = 1'b0;
    logic        dec_valid = 1'b0;
    logic [15:0] dec_word = '0;
    logic        dec_err = 1'b0;
    logic [1:0]  sts;

    int n_cmp = 0;
    int n_bad = 0;
    int n_xfer = 0;
    int addr_bad = 0;
    int data_bad = 0;
    int req_bad = 0;
    int cyc = 0;
    logic [23:0] exp_addr = '0;
    bit mode_dec = 1'b0;
    bit bp_en = 1'b0;
    bit stall = 1'b0;
    bit finished = 1'b0;

    assign mem_rdata = mem_addr[15:0] ^ 16'h5A3C;

    fxjob_seq u_fxjob_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .enc_full(enc_full), .enc_push(enc_push),
        .enc_word(enc_word), .dec_valid(dec_valid), .dec_word(dec_word),
        .dec_pop(dec_pop), .dec_err(dec_err), .busy(busy), .sts(sts), .irq(irq)
    );

    always #(HALF) clk = ~clk;

    // memory and FIFO model, recording every transfer
    always begin
        @(negedge clk);
        enc_full  = bp_en && (cyc % 4 == 1);
        dec_valid = !(bp_en && (cyc % 3 == 2));
        #0.5;
        mem_gnt = mem_req && !stall && !(bp_en && (cyc % 2 == 0));
        #0.5;
        if (mem_req && !mem_we && enc_full) req_bad++;
        if (mem_req && mem_we && !dec_valid) req_bad++;
        if (mem_req && mem_gnt) begin
            n_xfer++;
            if (mem_addr != exp_addr) addr_bad++;
            exp_addr = exp_addr + 24'd1;
            if (mode_dec) begin
                if (!mem_we || mem_wdata != dec_word || !dec_pop || enc_push) data_bad++;
                dec_word = dec_word + 16'd1;
            end else begin
                if (mem_we || !enc_push || dec_pop || enc_word != (mem_addr[15:0] ^ 16'h5A3C))
                    data_bad++;
            end
        end
        cyc++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [23:0] base, input logic [15:0] lm1, input logic [15:0] wm1);
        wr(3'd0, base);
        wr(3'd1, {8'h00, lm1});
        wr(3'd2, {8'h00, wm1});
    endtask

    task automatic start(input bit dec, input bit single, input bit resume, input logic [23:0] first);
        @(negedge clk);
        n_xfer = 0; addr_bad = 0; data_bad = 0; req_bad = 0;
        mode_dec = dec; exp_addr = first;
        wr(3'd3, {20'h0, resume, single, dec, 1'b1});
    endtask

    task automatic wait_idle(input string req);
        bit done_ok;
        done_ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy) begin done_ok = 1'b1; break; end
        end
        chk(done_ok, {req, " job finishes"}, int'(busy), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !mem_req, "R1 idle after reset", int'({busy, mem_req}), 0);
        chk(sts == 2'b00 && !irq, "R1 status and irq clear", int'({irq, sts}), 0);
    endtask

    task automatic t_encode_block();
        wr(3'd4, 24'h1);
        setup(24'h12FFFE, 16'd2, 16'd3);
        start(1'b0, 1'b0, 1'b0, 24'h12FFFE);
        wait_idle("R4");
        chk(n_xfer == 12, "R4 block word count", n_xfer, 12);
        chk(addr_bad == 0, "R2 sequential addresses", addr_bad, 0);
        chk(data_bad == 0, "R2 words passed to encoder", data_bad, 0);
        chk(sts == 2'b01, "R4 done bit set", int'(sts), 1);
        chk(irq == 1'b1, "R10 irq on enabled done", int'(irq), 1);
    endtask

    task automatic t_w1c();
        repeat (6) @(negedge clk);
        chk(sts == 2'b01, "R9 done stays set", int'(sts), 1);
        wr(3'd5, 24'h2);
        chk(sts == 2'b01, "R9 clearing other bit keeps done", int'(sts), 1);
        wr(3'd5, 24'h1);
        chk(sts == 2'b00 && !irq, "R9 write one clears done", int'({irq, sts}), 0);
    endtask

    task automatic t_backpressure();
        bp_en = 1'b1;
        setup(24'h000100, 16'd1, 16'd4);
        start(1'b0, 1'b0, 1'b0, 24'h000100);
        wait_idle("R2");
        bp_en = 1'b0;
        chk(n_xfer == 10, "R4 count under stalls", n_xfer, 10);
        chk(req_bad == 0, "R2 no request while encoder full", req_bad, 0);
        chk(addr_bad == 0 && data_bad == 0, "R2 order under stalls", addr_bad + data_bad, 0);
        wr(3'd5, 24'h3);
    endtask

    task automatic t_decode();
        bp_en = 1'b1;
        dec_word = 16'hC000;
        setup(24'h400000, 16'd3, 16'd1);
        start(1'b1, 1'b0, 1'b0, 24'h400000);
        wait_idle("R3");
        bp_en = 1'b0;
        chk(n_xfer == 8, "R4 decode word count", n_xfer, 8);
        chk(data_bad == 0, "R3 writes carry decoded words", data_bad, 0);
        chk(req_bad == 0, "R3 no request without data", req_bad, 0);
        chk(addr_bad == 0, "R3 ascending write addresses", addr_bad, 0);
        chk(sts == 2'b01, "R4 decode done bit", int'(sts), 1);
        wr(3'd5, 24'h3);
    endtask

    task automatic t_single();
        setup(24'h050000, 16'd7, 16'd5);
        start(1'b0, 1'b1, 1'b0, 24'h050000);
        wait_idle("R5");
        chk(n_xfer == 6, "R5 single line word count", n_xfer, 6);
        chk(addr_bad == 0, "R5 single line addresses", addr_bad, 0);
        wr(3'd5, 24'h3);
    endtask

    task automatic t_resume();
        wr(3'd0, 24'hABCDEF);
        start(1'b0, 1'b1, 1'b1, 24'h050006);
        wait_idle("R6");
        chk(n_xfer == 6 && addr_bad == 0, "R6 encode resumes own pointer", addr_bad, 0);
        wr(3'd1, 24'd0);
        wr(3'd2, 24'd2);
        start(1'b1, 1'b0, 1'b1, 24'h400008);
        wait_idle("R6");
        chk(n_xfer == 3, "R6 decode resume count", n_xfer, 3);
        chk(addr_bad == 0, "R6 decode resumes own pointer", addr_bad, 0);
        wr(3'd5, 24'h3);
    endtask

    task automatic t_busy_start();
        setup(24'h002000, 16'd4, 16'd3);
        start(1'b0, 1'b0, 1'b0, 24'h002000);
        repeat (3) @(negedge clk);
        wr(3'd3, {20'h0, 1'b0, 1'b1, 1'b1, 1'b1});
        wait_idle("R7");
        chk(n_xfer == 20, "R7 start while busy ignored", n_xfer, 20);
        chk(data_bad == 0 && addr_bad == 0, "R7 direction unchanged", data_bad + addr_bad, 0);
        wr(3'd5, 24'h3);
    endtask

    task automatic t_error();
        wr(3'd4, 24'h3);
        setup(24'h600000, 16'd9, 16'd3);
        start(1'b1, 1'b0, 1'b0, 24'h600000);
        repeat (10) @(negedge clk);
        dec_err = 1'b1; stall = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R8 error ends job at once", int'({busy, mem_req}), 0);
        chk(sts == 2'b10, "R8 error bit only", int'(sts), 2);
        chk(irq == 1'b1, "R10 irq on enabled error", int'(irq), 1);
        chk(n_xfer < 40, "R8 job cut short", n_xfer, 39);
        dec_err = 1'b0; stall = 1'b0;
        wr(3'd4, 24'h1);
        @(negedge clk);
        chk(irq == 1'b0, "R10 masked error gives no irq", int'(irq), 0);
        wr(3'd5, 24'h2);
        chk(sts == 2'b00, "R9 error cleared by write one", int'(sts), 0);
    endtask

    task automatic t_err_in_encode();
        setup(24'h070000, 16'd1, 16'd3);
        dec_err = 1'b1;
        start(1'b0, 1'b0, 1'b0, 24'h070000);
        wait_idle("R8");
        dec_err = 1'b0;
        chk(n_xfer == 8, "R8 error ignored in encode", n_xfer, 8);
        chk(sts == 2'b01, "R8 encode ends with done only", int'(sts), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_encode_block();
        t_w1c();
        t_backpressure();
        t_decode();
        t_single();
        t_resume();
        t_busy_start();
        t_error();
        t_err_in_encode();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(2.0 * HALF * 200000.0);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1..R11 run: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule